// File: doc/BRIEF.md
# Hamming Serial Receiver with Single-Bit Correction

This block sits at the receiving end of a serial link that carries Hamming-protected words. Bits arrive one per clock while a qualifier is high, and the lowest codeword position comes first. When a full 30-bit word has been gathered, the block re-evaluates the five check groups. A per-word input selects even or odd parity. The failing groups form a syndrome, which names the position of a single flipped bit.

The block inverts the bit at that position. It then drops the five check bits and presents the 25 information bits. Alongside the data it reports the numeric error position and an error flag, and it pulses a one-cycle valid strobe. A syndrome of 31 points outside the word. In that case the block raises the flag, reports 31 and leaves the data as received.

Top module: `hamming_rx_correct`

## Requirements
- R1: Synchronous reset clears the bit counter, the collected bits and the output register, and deasserts `dec_valid`. A frame begun before reset is discarded, and the next frame starts with a fresh position 1.
- R2: A serial bit is taken only on a clock edge where `ser_valid` is high. Cycles with `ser_valid` low advance nothing, whatever `ser_bit` carries.
- R3: `dec_valid` is high for exactly one cycle, on the cycle that follows the clock edge that accepts the 30th bit of a frame. All decode outputs are registered on that same edge.
- R4: With `odd_sense` low (even parity) and a clean codeword, `err_flag` is 0, `err_pos` is 0 and `dec_data` equals the sent information bits.
- R5: With `odd_sense` high (odd parity) and a clean codeword, `err_flag` is 0, `err_pos` is 0 and `dec_data` equals the sent information bits.
- R6: When exactly one bit at position p (1 to 30) is flipped, `err_pos` is p and `err_flag` is 1. `dec_data` equals the original information bits, including the case where p is a check position.
- R7: A syndrome of 31 sets `err_flag` and sets `err_pos` to 31. No bit is inverted, so `dec_data` carries the received information bits unchanged.
- R8: Check bits sit at positions 1, 2, 4, 8 and 16. `dec_data[i]` is the i-th non-power-of-two position in ascending order, so bit 0 is position 3 and bit 24 is position 30.
- R9: Check group k, weighted 2^k, covers every position whose binary index has bit k set. In even mode a group passes when its XOR is 0, and in odd mode when its XOR is 1. The syndrome is the sum of the weights of the failing groups.
- R10: `odd_sense` is sampled on the edge that accepts the 30th bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_valid | input | 1 | Qualifies `ser_bit` on this edge |
| ser_bit | input | 1 | Serial codeword bit, position 1 first |
| odd_sense | input | 1 | 0 = even parity groups, 1 = odd parity groups |
| dec_valid | output | 1 | One-cycle strobe for a decoded word |
| dec_data | output | 25 | Corrected information bits, check bits removed |
| err_pos | output | 5 | Syndrome: 0 clean, 1 to 30 corrected position, 31 out of range |
| err_flag | output | 1 | Nonzero syndrome seen |

## Verification
The bench builds the block with its default parameters: five check bits and a 30-bit codeword. Because the word is shorter than 31, a syndrome of 31 can occur. The bench reaches it in two ways: by decoding an even-coded word in odd mode, and by flipping positions 1 and 30 together. Under these defaults the bench also flips every one of the 30 positions, check positions included, in both parity modes. This exercises each syndrome value that a single-bit error can produce.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } sense_e;

    // True when p is a check-bit position (a power of two)
    function automatic logic is_check_pos(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

endpackage

// File: rtl/hm_sipo.sv
module hm_sipo #(
    parameter int CODE_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [CODE_W-1:0] word_asm,
    output logic              word_done
);
    localparam int CNT_W = $clog2(CODE_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CODE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] shreg;
    } sipo_t;

    sipo_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // New bit enters at the top; after CODE_W shifts position 1 sits at bit 0
        word_asm  = {bit_in, st_q.shreg[CODE_W-1:1]};
        word_done = bit_vld && (st_q.cnt == LAST_CNT);
        if (bit_vld) begin
            st_d.shreg = word_asm;
            st_d.cnt   = (st_q.cnt == LAST_CNT) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST_CNT); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(st_q.cnt)); // R2

endmodule

// File: rtl/hm_syndrome.sv
module hm_syndrome #(
    parameter int CODE_W = 30,
    parameter int CHK_W  = 5
) (
    input  logic [CODE_W-1:0] word,
    input  logic              odd_sel,
    output logic [CHK_W-1:0]  syn
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_grp
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> k) & 1) != 0) acc = acc ^ word[p-1];
            end
            // Even: group fails on XOR 1; odd: group fails on XOR 0
            syn[k] = acc ^ odd_sel;
        end
    end

endmodule

// File: rtl/hm_fix.sv
module hm_fix #(
    parameter int CODE_W = 30,
    parameter int CHK_W  = 5,
    parameter int DATA_W = 25
) (
    input  logic [CODE_W-1:0] word,
    input  logic [CHK_W-1:0]  syn,
    output logic [CODE_W-1:0] fixed,
    output logic [DATA_W-1:0] data,
    output logic              err
);
    import hm_pkg::*;

    always_comb begin
        fixed = word;
        if ((syn != '0) && (int'(syn) <= CODE_W)) begin
            fixed[int'(syn) - 1] = ~word[int'(syn) - 1];
        end
        err = (syn != '0);
    end

    always_comb begin
        int j;
        j    = 0;
        data = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                data[j] = fixed[p-1];
                j++;
            end
        end
    end

endmodule

// File: rtl/hamming_rx_correct.sv
module hamming_rx_correct #(
    parameter int CODE_W = 30,
    parameter int CHK_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_valid,
    input  logic                       ser_bit,
    input  logic                       odd_sense,
    output logic                       dec_valid,
    output logic [CODE_W-CHK_W-1:0]    dec_data,
    output logic [CHK_W-1:0]           err_pos,
    output logic                       err_flag
);
    import hm_pkg::*;

    localparam int DATA_W = CODE_W - CHK_W;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [CHK_W-1:0]  pos;
        logic [DATA_W-1:0] data;
    } out_t;

    logic [CODE_W-1:0] word_asm;
    logic [CODE_W-1:0] word_fix;
    logic              word_done;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] fix_data;
    logic              fix_err;
    sense_e            sense;

    out_t out_d, out_q;

    assign sense = sense_e'(odd_sense);

    hm_sipo #(.CODE_W(CODE_W)) u_sipo (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (ser_valid),
        .bit_in    (ser_bit),
        .word_asm  (word_asm),
        .word_done (word_done)
    );

    hm_syndrome #(.CODE_W(CODE_W), .CHK_W(CHK_W)) u_syn (
        .word    (word_asm),
        .odd_sel (sense == SENSE_ODD),
        .syn     (syn)
    );

    hm_fix #(.CODE_W(CODE_W), .CHK_W(CHK_W), .DATA_W(DATA_W)) u_fix (
        .word  (word_asm),
        .syn   (syn),
        .fixed (word_fix),
        .data  (fix_data),
        .err   (fix_err)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = word_done;
        if (word_done) begin
            out_d.err  = fix_err;
            out_d.pos  = syn;
            out_d.data = fix_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign dec_valid = out_q.vld;
    assign dec_data  = out_q.data;
    assign err_pos   = out_q.pos;
    assign err_flag  = out_q.err;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !dec_valid); // R1

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid); // R3

    AST_VALID_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(ser_valid)); // R2

    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        word_done |-> ($countones(word_asm ^ word_fix) <= 1)); // R6

    AST_CLEAN_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (word_done && syn == '0) |-> (word_fix == word_asm)); // R4

    AST_OUT_RANGE_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (word_done && int'(syn) > CODE_W) |-> (word_fix == word_asm)); // R7

endmodule

// File: tb/hamming_rx_correct_tb.sv
module hamming_rx_correct_tb;

    localparam int CODE_W = 30;
    localparam int CHK_W  = 5;
    localparam int DATA_W = CODE_W - CHK_W;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  pos;
        logic              err;
        int                cyc;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ser_valid = 1'b0;
    logic              ser_bit = 1'b0;
    logic              odd_sense = 1'b0;
    logic              dec_valid;
    logic [DATA_W-1:0] dec_data;
    logic [CHK_W-1:0]  err_pos;
    logic              err_flag;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   frames = 0;
    int   pulses = 0;
    logic prev_v = 1'b0;

    hamming_rx_correct #(.CODE_W(CODE_W), .CHK_W(CHK_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .ser_valid (ser_valid),
        .ser_bit   (ser_bit),
        .odd_sense (odd_sense),
        .dec_valid (dec_valid),
        .dec_data  (dec_data),
        .err_pos   (err_pos),
        .err_flag  (err_flag)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic pow2(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Builds a codeword from the requirement text: data in ascending
    // non-power-of-two positions, check 2^k over positions with bit k set
    function automatic logic [CODE_W-1:0] encode(logic [DATA_W-1:0] d, logic odd);
        logic [CODE_W-1:0] cw;
        int j;
        cw = '0;
        j  = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!pow2(p)) begin
                cw[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < CHK_W; k++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> k) & 1) != 0 && p != (1 << k)) x = x ^ cw[p-1];
            end
            cw[(1 << k) - 1] = x ^ odd;
        end
        return cw;
    endfunction

    task automatic check(string req, logic ok, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic send_word(logic [CODE_W-1:0] cw, logic odd, logic gaps,
                             logic [DATA_W-1:0] ed, logic [CHK_W-1:0] ep,
                             logic ee, string req);
        exp_t it;
        for (int p = 1; p <= CODE_W; p++) begin
            if (gaps && (p % 4 == 0)) begin
                @(negedge clk);
                ser_valid = 1'b0;
                ser_bit   = ~cw[p-1];
                odd_sense = ~odd;
            end
            @(negedge clk);
            ser_valid = 1'b1;
            ser_bit   = cw[p-1];
            odd_sense = odd;
            if (p == CODE_W) begin
                it.data = ed;
                it.pos  = ep;
                it.err  = ee;
                it.cyc  = cyc + 1;
                it.req  = req;
                exp_q.push_back(it);
                frames++;
            end
        end
        @(negedge clk);
        ser_valid = 1'b0;
        odd_sense = ~odd;
    endtask

    // Monitor: pops the scoreboard when the design strobes a result
    always @(negedge clk) begin
        if (!rst) begin
            if (dec_valid && prev_v)
                check("R3", 1'b0, "valid longer than one cycle", 1, 0);
            if (dec_valid) begin
                exp_t e;
                pulses++;
                if (exp_q.size() == 0) begin
                    check("R2", 1'b0, "unexpected valid", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check("R3", cyc == e.cyc, "valid cycle", cyc, e.cyc);
                    check(e.req, dec_data == e.data, "data", int'(dec_data), int'(e.data));
                    check(e.req, err_pos == e.pos, "position", int'(err_pos), int'(e.pos));
                    check(e.req, err_flag == e.err, "flag", int'(err_flag), int'(e.err));
                end
            end
            prev_v = dec_valid;
        end else begin
            prev_v = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic [CODE_W-1:0] cw;

        repeat (3) @(negedge clk);
        check("R1", dec_valid == 1'b0, "valid in reset", int'(dec_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", dec_valid == 1'b0 && dec_data == '0 && err_pos == '0,
              "outputs after reset", int'(dec_data), 0);

        // R8: single information bits land at the mapped positions
        send_word(encode(25'h0000001, 1'b0), 1'b0, 1'b0, 25'h0000001, 5'd0, 1'b0, "R8");
        send_word(encode(25'h1000000, 1'b0), 1'b0, 1'b0, 25'h1000000, 5'd0, 1'b0, "R8");
        // R4: clean even words
        send_word(encode(25'h1555555, 1'b0), 1'b0, 1'b0, 25'h1555555, 5'd0, 1'b0, "R4");
        send_word(encode(25'h0ABCDEF, 1'b0), 1'b0, 1'b0, 25'h0ABCDEF, 5'd0, 1'b0, "R4");
        // R5: clean odd words
        send_word(encode(25'h0000000, 1'b1), 1'b1, 1'b0, 25'h0000000, 5'd0, 1'b0, "R5");
        send_word(encode(25'h1FFFFFF, 1'b1), 1'b1, 1'b0, 25'h1FFFFFF, 5'd0, 1'b0, "R5");
        // R2, R10: idle cycles with junk bits and a toggled mode input
        send_word(encode(25'h12345AB, 1'b0), 1'b0, 1'b1, 25'h12345AB, 5'd0, 1'b0, "R2");
        cw = encode(25'h0F0F0F0, 1'b1);
        cw[6] = ~cw[6];
        send_word(cw, 1'b1, 1'b1, 25'h0F0F0F0, 5'd7, 1'b1, "R10");

        // R6, R9: every single-bit position in both senses
        for (int p = 1; p <= CODE_W; p++) begin
            d  = DATA_W'(32'h9E3779B9 * p);
            cw = encode(d, 1'b0);
            cw[p-1] = ~cw[p-1];
            send_word(cw, 1'b0, 1'b0, d, CHK_W'(p), 1'b1, "R6");
            d  = DATA_W'(32'h7F4A7C15 * p);
            cw = encode(d, 1'b1);
            cw[p-1] = ~cw[p-1];
            send_word(cw, 1'b1, 1'b0, d, CHK_W'(p), 1'b1, "R9");
        end

        // R7: even word read in odd sense fails all five groups
        d = 25'h0333333;
        send_word(encode(d, 1'b0), 1'b1, 1'b0, d, 5'd31, 1'b1, "R7");
        // R7: positions 1 and 30 flipped, syndrome 1^30 = 31, no correction
        d  = 25'h0000F00;
        cw = encode(d, 1'b0);
        cw[0]  = ~cw[0];
        cw[29] = ~cw[29];
        send_word(cw, 1'b0, 1'b0, d ^ 25'h1000000, 5'd31, 1'b1, "R7");

        // R1: partial frame then reset; the next frame starts at position 1
        cw = encode(25'h1FFFFFF, 1'b0);
        for (int p = 1; p <= 12; p++) begin
            @(negedge clk);
            ser_valid = 1'b1;
            ser_bit   = cw[p-1];
        end
        @(negedge clk);
        ser_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", dec_valid == 1'b0, "valid during reset", int'(dec_valid), 0);
        rst = 1'b0;
        send_word(encode(25'h0246801, 1'b0), 1'b0, 1'b0, 25'h0246801, 5'd0, 1'b0, "R1");

        repeat (5) @(negedge clk);
        check("R3", exp_q.size() == 0, "pending results", exp_q.size(), 0);
        check("R3", pulses == frames, "pulse count", pulses, frames);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule